// File: doc/BRIEF.md
# Bit-Serial Reed-Muller Block Encoder

This block maps a stream of information bits onto a codeword of the Reed-Muller code of order 6 in 10 variables. The codeword has 1024 positions. Each position index j is read as ten binary variables, with bit i-1 of j taken as variable a_i. The block takes one information bit per clock. It stores no generator matrix. A sequencer lists the monomials of the variables in a fixed order, and each monomial yields one generator row on the fly. When the current information bit is 1, that row is XOR-ed into a 1024-bit accumulator.

A block of 848 bits is opened by a start request, which is accepted only while `ready` is high. After the last bit the codeword is held on `codeword` with `cw_valid` high. It stays there, unaffected by further data, until the next accepted start clears the accumulator and begins a new block.

Top module: `rm_block_encoder`

## Requirements
- R1: While reset is asserted and right after it, `ready` is 1, `din_ready` is 0, `cw_valid` is 0 and `codeword` is all zeros.
- R2: A cycle with `start` and `ready` both high opens a block. From the next cycle `din_ready` is 1, `ready` is 0, `cw_valid` is 0 and `codeword` is all zeros.
- R3: While `din_ready` is 1, every cycle with `din_valid` high consumes exactly one `din_bit`, and cycles with `din_valid` low consume nothing. `cw_valid` stays 0 until the 848th bit has been consumed.
- R4: Information bit k (counted from 0 in arrival order) is tied to the k-th monomial in this order: degree 0 (the empty monomial) first, then degrees 1 to 6 in ascending order. Within one degree, monomials come in ascending value of their 10-bit variable mask, where mask bit i-1 stands for a_i.
- R5: The generator row of a monomial with mask m has bit j equal to 1 exactly when (j AND m) equals m. The empty monomial therefore gives the all-ones row.
- R6: `codeword` bit j equals the XOR of bit j of the rows of all consumed information bits that were 1.
- R7: In the cycle after the 848th bit is consumed, `cw_valid` is 1, `ready` is 1 and `din_ready` is 0.
- R8: While `cw_valid` is 1 and no start is accepted, `codeword` and `cw_valid` stay unchanged, whatever is driven on `din_valid` and `din_bit`.
- R9: `start` has no effect while a block is being loaded (`ready` is 0). The block in progress completes with the same codeword.
- R10: A start accepted while a codeword is held clears it and encodes a fresh block, with no carry-over from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to open a new block |
| ready | output | 1 | High when a start will be accepted |
| din_valid | input | 1 | Information bit present |
| din_bit | input | 1 | Information bit |
| din_ready | output | 1 | High while the block accepts information bits |
| cw_valid | output | 1 | Codeword complete and held |
| codeword | output | 1024 | Accumulated codeword, bit j at index j |

## Verification
One-hot blocks, where a single 1 sits at row 0, row 1, row 11 or row 847, show each generator row on its own. They separate a wrong monomial order or a wrong subset test from a wrong accumulation. All-zero and all-one blocks confirm that clearing works and that all rows combine correctly. Random blocks with random idle cycles and stray start pulses show that stalls neither skip nor repeat a row and that a start during loading is ignored. After the final block, data driven while the codeword is held shows that a finished codeword cannot be disturbed.

// File: rtl/rm_enc_pkg.sv
package rm_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } enc_state_e;

  function automatic int binom(input int n, input int k);
    int acc;
    acc = 1;
    for (int i = 0; i < k; i++) begin
      acc = acc * (n - i) / (i + 1);
    end
    return acc;
  endfunction

  // number of monomials of degree 0..order in nvar variables
  function automatic int rm_dim(input int nvar, input int order);
    int sum;
    sum = 0;
    for (int d = 0; d <= order; d++) begin
      sum = sum + binom(nvar, d);
    end
    return sum;
  endfunction

endpackage

// File: rtl/rm_mono_seq.sv
module rm_mono_seq #(
  parameter int NVAR = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  output logic [NVAR-1:0] mask
);

  logic [NVAR-1:0] mask_q, mask_d, mask_succ;
  logic [NVAR:0]   c_w, low_w, sum_w, tail_w;
  int              lsb;
  int              pop;

  // successor of the current mask: same popcount, next larger value;
  // after the largest mask of a degree, the smallest of the next degree
  always_comb begin
    lsb = 0;
    for (int i = NVAR - 1; i >= 0; i--) begin
      if (mask_q[i]) lsb = i;
    end
    pop    = $countones(mask_q);
    c_w    = {1'b0, mask_q};
    low_w  = c_w & (~c_w + 1'b1);
    sum_w  = c_w + low_w;
    tail_w = ((sum_w ^ c_w) >> lsb) >> 2;
    if (mask_q == '0) begin
      mask_succ = {{(NVAR-1){1'b0}}, 1'b1};
    end else if (sum_w[NVAR]) begin
      for (int i = 0; i < NVAR; i++) begin
        mask_succ[i] = (i <= pop);
      end
    end else begin
      mask_succ = sum_w[NVAR-1:0] | tail_w[NVAR-1:0];
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (clear) begin
      mask_d = '0;
    end else if (step) begin
      mask_d = mask_succ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  assign mask = mask_q;

  // R4: degree never decreases while stepping
  p_degree_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> ($countones(mask) >= $countones($past(mask))));

  // R4: within a degree the mask value strictly grows
  p_mask_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (($countones(mask) != $countones($past(mask))) ||
                          (mask > $past(mask))));

  // R2: a new block starts from the empty monomial
  p_clear_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mask == '0));

endmodule

// File: rtl/rm_row_gen.sv
module rm_row_gen #(
  parameter int NVAR = 10,
  localparam int NLEN = 1 << NVAR
) (
  input  logic [NVAR-1:0] mask,
  output logic [NLEN-1:0] row
);

  for (genvar j = 0; j < NLEN; j++) begin : g_pos
    localparam logic [NVAR-1:0] IDX = NVAR'(j);
    assign row[j] = ((IDX & mask) == mask);
  end

endmodule

// File: rtl/rm_enc_ctrl.sv
module rm_enc_ctrl
  import rm_enc_pkg::*;
#(
  parameter int NBITS = 848,
  localparam int CW = $clog2(NBITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic din_valid,
  output logic ready,
  output logic din_ready,
  output logic cw_valid,
  output logic take,
  output logic clear
);

  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  enc_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign ready     = (state_q != ST_LOAD);
  assign din_ready = (state_q == ST_LOAD);
  assign cw_valid  = (state_q == ST_DONE);
  assign clear     = start && ready;
  assign take      = din_ready && din_valid;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_LOAD;
          cnt_d   = '0;
        end
      end
      ST_LOAD: begin
        if (din_valid) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3: never more rows than the code dimension
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> (cnt_q < CW'(NBITS)));

  // R7: last consumed bit completes the block
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_q == LAST) |=> (cw_valid && ready && !din_ready));

  // R9: start while loading does not leave the load phase
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (din_ready && !(take && cnt_q == LAST)) |=> din_ready);

  // R8: held codeword stays valid until a start
  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !start) |=> cw_valid);

endmodule

// File: rtl/rm_block_encoder.sv
module rm_block_encoder
  import rm_enc_pkg::*;
#(
  parameter int NVAR  = 10,
  parameter int ORDER = 6,
  localparam int NLEN  = 1 << NVAR,
  localparam int NBITS = rm_dim(NVAR, ORDER)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            ready,
  input  logic            din_valid,
  input  logic            din_bit,
  output logic            din_ready,
  output logic            cw_valid,
  output logic [NLEN-1:0] codeword
);

  logic            take, clear;
  logic [NVAR-1:0] mask;
  logic [NLEN-1:0] row;
  logic [NLEN-1:0] acc_q, acc_d;

  rm_enc_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .din_valid (din_valid),
    .ready     (ready),
    .din_ready (din_ready),
    .cw_valid  (cw_valid),
    .take      (take),
    .clear     (clear)
  );

  rm_mono_seq #(.NVAR(NVAR)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (take),
    .mask  (mask)
  );

  rm_row_gen #(.NVAR(NVAR)) u_row (
    .mask (mask),
    .row  (row)
  );

  always_comb begin
    acc_d = acc_q;
    if (clear) begin
      acc_d = '0;
    end else if (take && din_bit) begin
      acc_d = acc_q ^ row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign codeword = acc_q;

  // R2: accepted start empties the accumulator
  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> (codeword == '0));

  // R6: a zero information bit leaves the codeword alone
  p_zero_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (din_ready && !(din_valid && din_bit)) |=> $stable(codeword));

  // R8: held codeword is frozen
  p_hold_codeword_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !start) |=> $stable(codeword));

  // R5: first row of every block is the all-ones row
  p_first_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> (row == '1));

endmodule

// File: tb/rm_block_encoder_bench.sv
`timescale 1ns/1ps
module rm_block_encoder_bench;

  localparam int NV = 10;
  localparam int NL = 1024;
  localparam int NK = 848;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          ready;
  logic          din_valid;
  logic          din_bit;
  logic          din_ready;
  logic          cw_valid;
  logic [NL-1:0] codeword;

  int n_chk;
  int n_bad;
  int cycles;
  logic [NV-1:0] rowmask [NK];

  rm_block_encoder u_rm_block_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (ready),
    .din_valid (din_valid),
    .din_bit   (din_bit),
    .din_ready (din_ready),
    .cw_valid  (cw_valid),
    .codeword  (codeword)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monomial order from R4, counted independently of the design
  task automatic build_rows();
    int k;
    k = 0;
    for (int d = 0; d <= 6; d++) begin
      for (int m = 0; m < NL; m++) begin
        if ($countones(m[NV-1:0]) == d) begin
          rowmask[k] = m[NV-1:0];
          k++;
        end
      end
    end
  endtask

  // R5 and R6 applied directly
  function automatic logic [NL-1:0] expect_cw(input logic [NK-1:0] data);
    logic [NL-1:0] r;
    r = '0;
    for (int j = 0; j < NL; j++) begin
      for (int k = 0; k < NK; k++) begin
        if (data[k] && ((j[NV-1:0] & rowmask[k]) == rowmask[k])) r[j] = ~r[j];
      end
    end
    return r;
  endfunction

  task automatic run_block(input logic [NK-1:0] data, input int gap,
                           input bit poke, input string req);
    int idx;
    bit early_done;
    logic [NL-1:0] exp;
    exp = expect_cw(data);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(din_ready && !ready && !cw_valid, "R2", "handshake after start",
        NL'({din_ready, ready, cw_valid}), NL'(3'b100));
    chk(codeword == '0, "R2/R10", "codeword cleared", codeword, '0);
    idx = 0;
    early_done = 1'b0;
    while (idx < NK) begin
      if (idx == NK - 1 && !early_done) begin
        early_done = 1'b1;
        chk(!cw_valid && din_ready, "R3", "not done before last bit",
            NL'({cw_valid, din_ready}), NL'(2'b01));
      end
      din_valid = (gap == 0) || (($urandom % 100) >= gap);
      din_bit   = din_valid ? data[idx] : ($urandom % 2 == 1);
      start     = poke && ($urandom % 40 == 0);
      @(negedge clk);
      if (din_valid) idx++;
    end
    din_valid = 1'b0;
    din_bit   = 1'b0;
    start     = 1'b0;
    chk(cw_valid && ready && !din_ready, "R7", "done handshake",
        NL'({cw_valid, ready, din_ready}), NL'(3'b110));
    chk(codeword == exp, req, "codeword value", codeword, exp);
  endtask

  initial begin
    logic [NK-1:0] data;
    logic [NL-1:0] held;
    n_chk = 0;
    n_bad = 0;
    cycles = 0;
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    start = 1'b0;
    din_valid = 1'b0;
    din_bit = 1'b0;
    build_rows();
    repeat (3) @(negedge clk);
    chk(ready && !din_ready && !cw_valid && codeword == '0, "R1", "reset state",
        NL'({ready, din_ready, cw_valid, |codeword}), NL'(4'b1000));
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !din_ready && !cw_valid && codeword == '0, "R1", "after reset",
        NL'({ready, din_ready, cw_valid, |codeword}), NL'(4'b1000));

    data = '0;
    run_block(data, 0, 1'b0, "R6 all-zero");
    data = '1;
    run_block(data, 0, 1'b0, "R6 all-one");
    data = '0; data[0] = 1'b1;
    run_block(data, 0, 1'b0, "R5 row0 all-ones");
    data = '0; data[1] = 1'b1;
    run_block(data, 0, 1'b0, "R4/R5 row1 a1");
    data = '0; data[11] = 1'b1;
    run_block(data, 0, 1'b0, "R4 row11 a1a2");
    data = '0; data[NK-1] = 1'b1;
    run_block(data, 0, 1'b0, "R4 last row");
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < NK; w++) data[w] = $urandom % 2;
      run_block(data, (b == 0) ? 0 : 10 * b, b >= 2, (b >= 2) ? "R9/R3 random" : "R6 random");
    end

    held = codeword;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      din_valid = 1'b1;
      din_bit = (c % 2 == 0);
    end
    @(negedge clk);
    din_valid = 1'b0;
    chk(cw_valid == 1'b1, "R8", "valid held", NL'(cw_valid), NL'(1));
    chk(codeword == held, "R8", "codeword held under data", codeword, held);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule